// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and an external asynchronous static RAM of 1M words by 16 bits with separate active-low enables for the low and high byte. The host issues one word per request through a request/ready handshake, carrying a 20-bit word address, write data, a two-bit byte mask and a read/write flag. The controller turns each request into a strobe sequence on chip enable, write enable, output enable and the two byte enables. It also controls the shared data bus through a separate driver enable.

All timing is given in picoseconds as parameters and turned into whole clock cycles by rounding up. After reset the controller waits out the memory's power-up time before it accepts anything. Between accesses it releases chip enable so the memory drops into standby. Read data is registered once the access time is met and returned with a single-cycle valid pulse. Byte lanes that were not requested come back as zero.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, ready_o stays low and sram_ce_no stays high for PWR_CYC = ceil(T_PWRUP_PS / CLK_PERIOD_PS) rising edges. ready_o is first high after exactly PWR_CYC edges. A request raised before then starts no access.
- R2: A request is accepted on a rising edge where req_i and ready_o are both high. ready_o is low from the next cycle until the access has finished.
- R3: A write holds sram_ce_no and sram_we_no low together for WR_LEN cycles, where WR_LEN is the largest of ceil(T_WC), ceil(T_PWE), ceil(T_AW) and DRV_START + ceil(T_SD). Both strobes rise on the same edge. sram_oe_no stays high during the write unless OE_LOW_WR is 1.
- R4: During an access, sram_lb_no is the inverse of mask_i bit 0 (bits 7:0) and sram_ub_no is the inverse of mask_i bit 1 (bits 15:8), as captured at acceptance.
- R5: sram_dq_oe_o is high only while sram_we_no and sram_ce_no are low. It turns on DRV_START cycles into the write and stays on until the write ends. DRV_START is ceil(T_HZWE) when OE_LOW_WR is 1 and ceil(T_HZOE) otherwise. sram_dq_o carries the accepted write data.
- R6: A read holds sram_ce_no and sram_oe_no low with sram_we_no high for RD_LEN cycles, where RD_LEN is the largest of ceil(T_AA), ceil(T_DOE) and ceil(T_RC). Data is sampled at the end of the last read cycle. rvalid_o is high for exactly one cycle, RD_LEN+1 cycles after the accepting edge.
- R7: Byte lanes whose mask bit is 0 read back as zero in rdata_o.
- R8: Whenever ready_o is high, sram_ce_no, sram_we_no and sram_oe_no are high and sram_dq_oe_o is low, so the memory sits in standby.
- R9: A write with mask 00 enables no byte lane and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Byte mask, bit 0 = low byte |
| ready_o | output | 1 | Controller can accept a request |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 16 | Read data |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_lb_no | output | 1 | Low byte enable, active low |
| sram_ub_no | output | 1 | High byte enable, active low |
| sram_addr_o | output | 20 | Memory address |
| sram_dq_o | output | 16 | Data to memory |
| sram_dq_oe_o | output | 1 | Data bus driver enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The bench drives random sequences of reads and writes over a small set of addresses that includes the lowest and highest word. All four mask values are used, and the results are compared against a shadow memory. Masks 01 and 10 show whether each byte strobe and the read-data zeroing act on the correct lane. Mask 00 shows that a strobed write with no lane enabled does not corrupt storage. Back-to-back requests show the standby gap and the ready timing. A request held during power-up shows that nothing starts before the wait has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} seq_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_pwr_timer.sv
module sram_pwr_timer #(
  parameter int PWR_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int PW = $clog2(PWR_CYC + 2);
  logic [PW-1:0] cnt_q;

  assign done_o = (cnt_q == PW'(PWR_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int LANES      = DW / 8,
  parameter int WR_LEN     = 2,
  parameter int RD_LEN     = 1,
  parameter int DRV_START  = 1,
  parameter bit OE_LOW_WR  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_done_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] mask_i,
  output logic             ready_o,
  output logic             cap_o,
  output logic [LANES-1:0] mask_q_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             oe_no,
  output logic [LANES-1:0] be_no,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  localparam int CW = $clog2(imax(WR_LEN, RD_LEN) + 1);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q;
  logic             wr_last, rd_last;

  assign ready_o = (state_q == ST_IDLE) && pwr_done_i;
  assign wr_last = (state_q == ST_WR) && (cnt_q == CW'(WR_LEN - 1));
  assign rd_last = (state_q == ST_RD) && (cnt_q == CW'(RD_LEN - 1));
  assign cap_o   = rd_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i && ready_o) begin
          state_q <= we_i ? ST_WR : ST_RD;
          cnt_q   <= '0;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          mask_q  <= mask_i;
        end
        ST_WR: if (wr_last) state_q <= ST_IDLE;
               else         cnt_q   <= cnt_q + 1'b1;
        ST_RD: if (rd_last) state_q <= ST_IDLE;
               else         cnt_q   <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_no    = (state_q == ST_IDLE);
  assign we_no    = (state_q != ST_WR);
  assign oe_no    = !((state_q == ST_RD) || (OE_LOW_WR && (state_q == ST_WR)));
  assign addr_o   = addr_q;
  assign dq_o     = wdata_q;
  assign dq_oe_o  = (state_q == ST_WR) && (cnt_q >= CW'(DRV_START));
  assign mask_q_o = mask_q;

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_no[l] = (state_q == ST_IDLE) || !mask_q[l];
  end

  p_no_early_access_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done_i |-> ce_no);
  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  p_we_inside_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ce_no);
  p_drive_in_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!we_no && !ce_no));
  p_drive_until_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && !wr_last) |=> dq_oe_o);
  p_standby_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_no && we_no && oe_no && !dq_oe_o));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic [DW-1:0] lane_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{mask_i[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i & lane_mask;
    end
  end

  p_rvalid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rdata_o));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_PWRUP_PS    = 1000000000,
  parameter int T_WC_PS       = 10000,
  parameter int T_PWE_PS      = 7000,
  parameter int T_AW_PS       = 7000,
  parameter int T_SD_PS       = 5500,
  parameter int T_HZWE_PS     = 5000,
  parameter int T_HZOE_PS     = 5000,
  parameter int T_AA_PS       = 10000,
  parameter int T_DOE_PS      = 5000,
  parameter int T_RC_PS       = 10000,
  parameter bit OE_LOW_WR     = 1'b0,
  parameter int AW            = 20,
  parameter int DW            = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    mask_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic          sram_lb_no,
  output logic          sram_ub_no,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int LANES     = DW / 8;
  localparam int PWR_CYC   = cdiv(T_PWRUP_PS, CLK_PERIOD_PS);
  localparam int DRV_START = OE_LOW_WR ? cdiv(T_HZWE_PS, CLK_PERIOD_PS)
                                       : cdiv(T_HZOE_PS, CLK_PERIOD_PS);
  localparam int WR_LEN    = imax(imax(cdiv(T_WC_PS, CLK_PERIOD_PS), cdiv(T_PWE_PS, CLK_PERIOD_PS)),
                                  imax(cdiv(T_AW_PS, CLK_PERIOD_PS),
                                       DRV_START + cdiv(T_SD_PS, CLK_PERIOD_PS)));
  localparam int RD_LEN    = imax(imax(cdiv(T_AA_PS, CLK_PERIOD_PS), cdiv(T_DOE_PS, CLK_PERIOD_PS)),
                                  imax(cdiv(T_RC_PS, CLK_PERIOD_PS), 1));

  logic             pwr_done, cap;
  logic [LANES-1:0] mask_q, be_n;

  sram_pwr_timer #(.PWR_CYC(PWR_CYC)) u_pwr (
    .clk_i, .rst_ni, .done_o(pwr_done)
  );

  sram_seq #(
    .AW(AW), .DW(DW), .LANES(LANES), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN),
    .DRV_START(DRV_START), .OE_LOW_WR(OE_LOW_WR)
  ) u_seq (
    .clk_i, .rst_ni, .pwr_done_i(pwr_done), .req_i, .we_i, .addr_i, .wdata_i,
    .mask_i(mask_i[LANES-1:0]), .ready_o, .cap_o(cap), .mask_q_o(mask_q),
    .ce_no(sram_ce_no), .we_no(sram_we_no), .oe_no(sram_oe_no), .be_no(be_n),
    .addr_o(sram_addr_o), .dq_o(sram_dq_o), .dq_oe_o(sram_dq_oe_o)
  );

  sram_rd_capture #(.DW(DW), .LANES(LANES)) u_cap (
    .clk_i, .rst_ni, .cap_i(cap), .mask_i(mask_q), .dq_i(sram_dq_i),
    .rdata_o, .rvalid_o
  );

  assign sram_lb_no = be_n[0];
  assign sram_ub_no = be_n[LANES-1];
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int CLK_PS   = 10000;
  localparam int PWRUP_PS = 1000000;
  localparam int PWR_CYC  = (PWRUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int DRV_START = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int WR_LEN   = 2;
  localparam int RD_LEN   = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic ready, rvalid, ce_n, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [19:0] sram_addr;

  int checks = 0, errors = 0;
  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  logic [1:0]  cur_mask = '0;
  int we_run = 0, rd_run = 0;
  bit drv_seen = 0;

  always #5ns clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_PS(CLK_PS), .T_PWRUP_PS(PWRUP_PS)) u_dut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .mask_i(mask), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_lb_no(lb_n),
    .sram_ub_no(ub_n), .sram_addr_o(sram_addr), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  function automatic logic [15:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always_comb begin
    logic [15:0] w;
    w = mem_rd(int'(sram_addr));
    dq_i = 16'hzzzz;
    if (!ce_n && !oe_n && we_n) begin
      if (!lb_n) dq_i[7:0]  = w[7:0];
      if (!ub_n) dq_i[15:8] = w[15:8];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model and strobe monitors
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!ce_n && !we_n && dq_oe) begin
        logic [15:0] w;
        w = mem_rd(int'(sram_addr));
        if (!lb_n) w[7:0]  = dq_o[7:0];
        if (!ub_n) w[15:8] = dq_o[15:8];
        mem[int'(sram_addr)] = w;
      end
      if (dq_oe && (we_n || ce_n)) chk(0, "R5 driver outside write", {we_n, ce_n}, 0);
      if (!ce_n && ({ub_n, lb_n} != ~cur_mask))
        chk(0, "R4 byte enables", {ub_n, lb_n}, ~cur_mask);
      if (!we_n) begin
        if (oe_n != 1'b1) chk(0, "R3 oe during write", oe_n, 1);
        if (dq_oe && !drv_seen) begin
          chk(we_run == DRV_START, "R5 drive start", we_run, DRV_START);
          drv_seen = 1;
        end
        we_run++;
      end else if (we_run != 0) begin
        chk(we_run == WR_LEN, "R3 write strobe width", we_run, WR_LEN);
        chk(ce_n, "R3 ce released with we", ce_n, 1);
        we_run = 0;
        drv_seen = 0;
      end
      if (!oe_n && we_n && !ce_n) rd_run++;
      else if (rd_run != 0) begin
        chk(rd_run == RD_LEN, "R6 read strobe width", rd_run, RD_LEN);
        rd_run = 0;
      end
      if (ready) chk(ce_n && we_n && oe_n && !dq_oe, "R8 standby", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    end
  end

  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
    int n;
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; mask = m; cur_mask = m;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    chk(!ready, "R2 ready low after accept", ready, 0);
    n = 1;
    while (!ready && n < 50) begin @(negedge clk); n++; end
    chk(n == WR_LEN + 1, "R2 write busy length", n, WR_LEN + 1);
    begin
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end
  endtask

  task automatic do_read(input logic [19:0] a, input logic [1:0] m, input string rq);
    int n;
    logic [15:0] exp;
    while (!ready) @(negedge clk);
    req = 1; we = 0; addr = a; mask = m; cur_mask = m;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    n = 1;
    while (!rvalid && n < 50) begin @(negedge clk); n++; end
    chk(n == RD_LEN + 1, "R6 rvalid timing", n, RD_LEN + 1);
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    exp = exp & {{8{m[1]}}, {8{m[0]}}};
    chk(rdata === exp, rq, rdata, exp);
    @(negedge clk);
    chk(!rvalid, "R6 rvalid single pulse", rvalid, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    logic [19:0] pool [8];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!ready && ce_n && we_n && oe_n && !dq_oe, "R1 reset state", {ready, ce_n, we_n, oe_n, dq_oe}, 5'b01110);
    rst_ni = 1;
    req = 1; we = 1; addr = 20'h12345; wdata = 16'hdead; mask = 2'b11;
    n = 0;
    while (!ready && n < PWR_CYC + 10) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 20) req = 0;
      if (!ready && !ce_n) chk(0, "R1 strobe before power-up", ce_n, 1);
    end
    chk(n == PWR_CYC, "R1 power-up length", n, PWR_CYC);
    repeat (3) @(negedge clk);
    chk(ce_n, "R1 early request dropped", ce_n, 1);
    do_read(20'h12345, 2'b11, "R1 early request wrote nothing");

    do_write(20'h00000, 16'ha55a, 2'b11);
    do_write(20'hfffff, 16'h1234, 2'b11);
    do_read(20'h00000, 2'b11, "R6 read low address");
    do_read(20'hfffff, 2'b11, "R6 read top address");
    do_write(20'hfffff, 16'hbeef, 2'b01);
    do_read(20'hfffff, 2'b11, "R4 low lane only write");
    do_write(20'hfffff, 16'hc0de, 2'b10);
    do_read(20'hfffff, 2'b11, "R4 high lane only write");
    do_read(20'hfffff, 2'b01, "R7 high lane zeroed");
    do_read(20'hfffff, 2'b10, "R7 low lane zeroed");
    do_write(20'h00000, 16'h0f0f, 2'b00);
    do_read(20'h00000, 2'b11, "R9 mask 00 no change");

    for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
    pool[0] = 20'h00000;
    pool[7] = 20'hfffff;
    for (int i = 0; i < 80; i++) begin
      logic [19:0] a;
      logic [1:0]  m;
      a = pool[$urandom % 8];
      m = 2'($urandom);
      if ($urandom % 2) do_write(a, 16'($urandom), m);
      else              do_read(a, m, "R6 random read data");
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule